// File: doc/BRIEF.md
# Multi-Page-Size Address Translation Buffer

This block is a fully associative translation buffer of 32 entries. It maps the page number of an effective address to a physical frame. A lookup presents a 32-bit effective address and the current 4-bit address-space tag. In the same cycle the block answers with a hit flag, the translated physical address and the 4-bit protection group of the matching entry. Each entry carries its own page size: 4 KB, 16 KB, 512 KB or 8 MB. That size sets how many low address bits are left out of the compare and copied straight into the physical address. An entry can also be marked global, in which case it matches under every address space.

Software reloads one entry at a time through a write port addressed by an index. A single invalidate-all command empties the whole buffer in one cycle. Instruction and data translation each use their own instance of this block. Table walking and permission evaluation sit outside it.

Top module: `tlb_multi_page`

## Requirements
- R1: After reset no entry is valid and every lookup misses. Whenever the lookup misses, the physical address and group outputs are zero.
- R2: The size field is 2 bits, with S = 12, 14, 19, 23 for codes 0, 1, 2, 3. An entry's page-number compare covers effective address bits [31:S] only.
- R3: On a hit, the physical address takes bits [31:S] from the entry's frame number and bits [S-1:0] from the effective address.
- R4: A valid entry matches only when its address-space tag equals the lookup tag, or when its global bit is set.
- R5: On a hit the protection group stored in the matching entry is returned.
- R6: A write with the write-enable high replaces the whole entry at the given index. The new contents are seen by lookups from the next cycle on.
- R7: Invalidate-all clears every entry in one cycle. It takes precedence over a write issued in the same cycle.
- R8: When several entries match, the entry with the lowest index supplies the result.
- R9: A lookup is combinational: hit or miss, address and group follow the request inputs within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_ea | input | 32 | Effective address to translate |
| lk_asid | input | 4 | Current address-space tag |
| lk_hit | output | 1 | A matching entry was found |
| lk_pa | output | 32 | Translated physical address, zero on miss |
| lk_grp | output | 4 | Protection group of the matching entry, zero on miss |
| wr_en | input | 1 | Write one entry |
| wr_idx | input | 5 | Entry index to write |
| wr_pn | input | 20 | Effective page number (address bits 31:12) |
| wr_fn | input | 20 | Physical frame number (address bits 31:12) |
| wr_size | input | 2 | Page size code |
| wr_asid | input | 4 | Address-space tag of the entry |
| wr_global | input | 1 | Entry matches under every address space |
| wr_grp | input | 4 | Protection group of the entry |
| inv_all | input | 1 | Clear every entry |

## Verification
The hardest case to reach is the interaction between per-entry masks. A large page has to swallow addresses that a smaller page also claims, and the lowest index must then win. Frame bits under the mask must also be shown to be discarded. The bench fills every entry with a rotating size, tag and global pattern. Frame numbers carry non-zero low bits on purpose. It sweeps each page's first, middle and last byte plus the first byte beyond the page, under the own tag and a foreign tag. It then builds deliberately nested pages, checks which entry wins, and compares everything against an arithmetic model.

// File: rtl/tlb_multi_page.sv
module tlb_multi_page #(
  parameter int ENTRIES = 32,
  parameter int EA_W    = 32,
  parameter int ASID_W  = 4,
  parameter int GRP_W   = 4,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int PN_W   = EA_W - 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EA_W-1:0]   lk_ea,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic [EA_W-1:0]   lk_pa,
  output logic [GRP_W-1:0]  lk_grp,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [PN_W-1:0]   wr_pn,
  input  logic [PN_W-1:0]   wr_fn,
  input  logic [1:0]        wr_size,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [GRP_W-1:0]  wr_grp,
  input  logic              inv_all
);

  function automatic logic [PN_W-1:0] low_mask(input logic [1:0] sz);
    logic [PN_W-1:0] one;
    one = 1;
    case (sz)
      2'd0:    return '0;
      2'd1:    return (one << 2) - one;
      2'd2:    return (one << 7) - one;
      default: return (one << 11) - one;
    endcase
  endfunction

  logic [ENTRIES-1:0] v;
  logic [PN_W-1:0]    e_pn  [ENTRIES];
  logic [PN_W-1:0]    e_fn  [ENTRIES];
  logic [1:0]         e_sz  [ENTRIES];
  logic [ASID_W-1:0]  e_as  [ENTRIES];
  logic               e_gl  [ENTRIES];
  logic [GRP_W-1:0]   e_grp [ENTRIES];

  logic [PN_W-1:0]    msk   [ENTRIES];
  logic [ENTRIES-1:0] match;
  wire  [PN_W-1:0]    ea_pn = lk_ea[EA_W-1:12];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      v <= '0;
    else if (inv_all) v <= '0;
    else if (wr_en)   v[wr_idx] <= 1'b1;

  always_ff @(posedge clk)
    if (wr_en && !inv_all) begin
      e_pn[wr_idx]  <= wr_pn;
      e_fn[wr_idx]  <= wr_fn;
      e_sz[wr_idx]  <= wr_size;
      e_as[wr_idx]  <= wr_asid;
      e_gl[wr_idx]  <= wr_global;
      e_grp[wr_idx] <= wr_grp;
    end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign msk[i]   = low_mask(e_sz[i]);
    assign match[i] = v[i] && (e_gl[i] || e_as[i] == lk_asid)
                      && (((e_pn[i] ^ ea_pn) & ~msk[i]) == '0);
  end

  always_comb begin
    lk_hit = 1'b0;
    lk_pa  = '0;
    lk_grp = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (match[i]) begin
        lk_hit = 1'b1;
        lk_pa  = {(e_fn[i] & ~msk[i]) | (ea_pn & msk[i]), lk_ea[11:0]};
        lk_grp = e_grp[i];
      end
  end

endmodule

// File: rtl/tlb_multi_page_chk.sv
module tlb_multi_page_chk #(
  parameter int ENTRIES = 32,
  parameter int EA_W    = 32,
  parameter int ASID_W  = 4,
  parameter int GRP_W   = 4,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int PN_W   = EA_W - 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [EA_W-1:0]   lk_ea,
  input logic [ASID_W-1:0] lk_asid,
  input logic              lk_hit,
  input logic [EA_W-1:0]   lk_pa,
  input logic [GRP_W-1:0]  lk_grp,
  input logic              wr_en,
  input logic [IDX_W-1:0]  wr_idx,
  input logic [PN_W-1:0]   wr_pn,
  input logic [PN_W-1:0]   wr_fn,
  input logic [1:0]        wr_size,
  input logic [ASID_W-1:0] wr_asid,
  input logic              wr_global,
  input logic [GRP_W-1:0]  wr_grp,
  input logic              inv_all
);

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_pa == '0 && lk_grp == '0)); // R1

  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> lk_pa[11:0] == lk_ea[11:0]); // R3

  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en && !inv_all) && lk_asid == $past(wr_asid)
     && lk_ea[EA_W-1:12] == $past(wr_pn)) |-> lk_hit); // R6

  AST_INV_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> !lk_hit); // R7

endmodule

bind tlb_multi_page tlb_multi_page_chk #(
  .ENTRIES(ENTRIES), .EA_W(EA_W), .ASID_W(ASID_W), .GRP_W(GRP_W)
) chk (.*);

// File: tb/tlb_multi_page_test.sv
module tlb_multi_page_test;
  localparam int N = 32;

  logic        clk = 0, rst_n = 0;
  logic [31:0] lk_ea = 0;
  logic [3:0]  lk_asid = 0;
  logic        lk_hit;
  logic [31:0] lk_pa;
  logic [3:0]  lk_grp;
  logic        wr_en = 0, wr_global = 0, inv_all = 0;
  logic [4:0]  wr_idx = 0;
  logic [19:0] wr_pn = 0, wr_fn = 0;
  logic [1:0]  wr_size = 0;
  logic [3:0]  wr_asid = 0, wr_grp = 0;

  int tests = 0, fails = 0;

  logic        m_v  [N];
  logic [19:0] m_pn [N], m_fn [N];
  logic [1:0]  m_sz [N];
  logic [3:0]  m_as [N], m_grp [N];
  logic        m_gl [N];

  always #2 clk = ~clk;

  tlb_multi_page uut (.*);

  function automatic int shift_of(input logic [1:0] sz);
    case (sz) 2'd0: return 12; 2'd1: return 14; 2'd2: return 19; default: return 23; endcase
  endfunction

  task automatic do_write(input int idx, input logic [19:0] pn, fn, input logic [1:0] sz,
                          input logic [3:0] as, input logic gl, input logic [3:0] grp);
    @(negedge clk);
    wr_en = 1; wr_idx = 5'(idx); wr_pn = pn; wr_fn = fn; wr_size = sz;
    wr_asid = as; wr_global = gl; wr_grp = grp;
    @(negedge clk);
    wr_en = 0;
    m_v[idx] = 1; m_pn[idx] = pn; m_fn[idx] = fn; m_sz[idx] = sz;
    m_as[idx] = as; m_gl[idx] = gl; m_grp[idx] = grp;
  endtask

  task automatic probe(input logic [31:0] ea, input logic [3:0] as, input string req);
    logic        e_hit = 0;
    logic [31:0] e_pa = 0;
    logic [3:0]  e_grp = 0;
    lk_ea = ea; lk_asid = as;
    #1;
    for (int i = N - 1; i >= 0; i--) begin
      int s = shift_of(m_sz[i]);
      if (m_v[i] && (m_gl[i] || m_as[i] == as) && ((ea >> s) == ({m_pn[i], 12'h0} >> s))) begin
        e_hit = 1;
        e_pa  = (({m_fn[i], 12'h0} >> s) << s) | (ea & ((32'd1 << s) - 1));
        e_grp = m_grp[i];
      end
    end
    tests++;
    if (lk_hit !== e_hit || lk_pa !== e_pa || lk_grp !== e_grp) begin
      fails++;
      $display("FAIL %s ea=%h asid=%0d: got hit=%b pa=%h grp=%h, want hit=%b pa=%h grp=%h",
               req, ea, as, lk_hit, lk_pa, lk_grp, e_hit, e_pa, e_grp);
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < N; i++) m_v[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: empty after reset
    for (int k = 0; k < 8; k++) probe(32'h1000_0000 * k + 32'h123, 4'(k), "R1");

    // R2 R3 R4 R5: fill with rotating size, tag and global pattern
    for (int i = 0; i < N; i++)
      do_write(i, 20'(i << 11), {9'(i * 3 + 1), 11'h5A5}, 2'(i % 4),
               4'(i % 16), (i % 8) == 7, 4'(15 - i % 16));
    for (int i = 0; i < N; i++) begin
      int s = shift_of(2'(i % 4));
      logic [31:0] base = 32'(i) << 23;
      probe(base, 4'(i % 16), "R2");
      probe(base + (32'd1 << (s - 1)) + 32'h35, 4'(i % 16), "R3");
      probe(base + (32'd1 << s) - 1, 4'(i % 16), "R3");
      probe(base + (32'd1 << s), 4'(i % 16), "R2");
      probe(base + 32'h7FF, 4'((i + 5) % 16), "R4");
      probe(base + 32'h10, 4'(i % 16), "R5");
    end
    // R9: back-to-back changes of the request in consecutive steps with no clock
    probe(32'h0080_0004, 4'd1, "R9");
    probe(32'h0100_0004, 4'd2, "R9");

    // R6: overwrite entry 5 with a different page
    do_write(5, 20'hABCDE, 20'h13579, 2'd0, 4'd9, 0, 4'd3);
    probe(32'h0280_0000, 4'd5, "R6");
    probe(32'hABCD_E456, 4'd9, "R6");
    probe(32'hABCD_E456, 4'd8, "R4");

    // R8: nested pages, lowest index wins
    do_write(1, 20'hF0000, 20'h22222, 2'd3, 4'd0, 1, 4'd7);
    do_write(20, 20'hF0123, 20'h44444, 2'd0, 4'd0, 1, 4'd2);
    probe(32'hF012_3ABC, 4'd6, "R8");
    do_write(1, 20'h00000, 20'h00000, 2'd0, 4'd0, 0, 4'd0);
    probe(32'hF012_3ABC, 4'd6, "R8");
    probe(32'hF012_4ABC, 4'd6, "R2");

    // R7: invalidate-all beats a same-cycle write
    @(negedge clk);
    inv_all = 1; wr_en = 1; wr_idx = 5'd3; wr_pn = 20'h55555; wr_fn = 20'h1;
    wr_size = 0; wr_asid = 0; wr_global = 1; wr_grp = 4'd1;
    @(negedge clk);
    inv_all = 0; wr_en = 0;
    for (int i = 0; i < N; i++) m_v[i] = 0;
    probe(32'h5555_5000, 4'd0, "R7");
    probe(32'hF012_3ABC, 4'd6, "R7");
    probe(32'hABCD_E456, 4'd9, "R7");
    do_write(3, 20'h55555, 20'h00001, 2'd0, 4'd0, 1, 4'd1);
    probe(32'h5555_5FFF, 4'd4, "R6");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule